// File: doc/BRIEF.md
# Reloading Timer/Event Counter with Square-Wave Drive

This block is an up-counting timer for a small controller. Software sets a preload value and a control word over a narrow register bus. The counter then advances on one of two sources: the internal clock through a power-of-two prescaler, or rising edges on an external event pin. When the count passes its all-ones value, the counter takes the preload value in the same clock. That wrap also sets a sticky overflow flag and flips a pair of complementary outputs, which can drive a buzzer as a square wave.

While the count register is being read, the counter does not advance, so software always sees a settled value. Any source tick that arrives during that read is dropped on purpose and is not made up later. A clock-enable input gates the internal source, so the whole timer can be slowed or paused from outside.

Top module: `tmr_pfd_top`

## Requirements
- R1: After reset, the count is 0, the preload is 0, the control word is 0 (stopped), the overflow flag is 0, `pfd_o` is 0 and `pfd_n_o` is 1.
- R2: While running on the internal source, the counter moves up by one every 2^N enabled clocks, where N is control bits [2:0] (0 to 7). Writing the control word restarts the prescaler phase.
- R3: A tick that arrives while the count is all ones loads the preload value instead of incrementing. With preload P and an n-bit counter, wraps therefore occur every (2^n - P) * 2^N enabled clocks.
- R4: Each wrap inverts `pfd_o` and `pfd_n_o`, and `pfd_n_o` is always the complement of `pfd_o`.
- R5: In any cycle where `bus_rd` is high with address 0, the count does not change, and the dropped tick is not recovered.
- R6: With control bit 3 set, the counter advances once per rising edge of `ext_evt_i`, after a three-flop synchronizer. An input held high counts only once.
- R7: With control bit 4 (run) clear, the count holds. Writing address 0 while stopped loads the counter as well as the preload. Writing address 0 while running changes only the preload.
- R8: The overflow flag is set by every wrap and stays set until a write to address 2. If a wrap and a clear fall in the same cycle, the wrap wins.
- R9: While `clk_en_i` is low, the internal source does not advance the counter.
- R10: Register map: address 0 writes the preload and reads the count, zero-extended. Address 1 writes and reads the control word (bits [4:0]). Address 2 reads the flag in bit 0. Address 3 reads 0. Read data is registered and appears one clock after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_i | input | 1 | Enable for the internal count source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ext_evt_i | input | 1 | Asynchronous external event input |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| pfd_o | output | 1 | Square-wave output, toggled on each wrap |
| pfd_n_o | output | 1 | Complement of `pfd_o` |

## Verification
The bench builds the block with a 4-bit counter, keeping the default 8-bit bus and 3-bit prescale field. At that size, every preload value can be crossed with every prescale stage, and the wrap period is measured from the square-wave output against (16 - P) * 2^N. The arithmetic is modulo 16, so the stalled-read, stopped-hold and external-edge cases can each be checked as an exact count difference, even across wraps.

// File: rtl/tmr_pfd_pkg.sv
package tmr_pfd_pkg;
  localparam int PSC_SEL_W = 3;

  typedef enum logic [1:0] {
    ADR_COUNT = 2'd0,
    ADR_CTRL  = 2'd1,
    ADR_FLAG  = 2'd2,
    ADR_NONE  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic                 run;
    logic                 src_ext;
    logic [PSC_SEL_W-1:0] psc_sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             clk_en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] psc_q;
  logic [DIV_W-1:0] mask;

  for (genvar g = 0; g < DIV_W; g++) begin : g_mask
    assign mask[g] = (int'(sel) > g);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) psc_q <= '0;
    else if (clk_en) psc_q <= psc_q + DIV_W'(1);
  end

  assign tick = clk_en && ((psc_q & mask) == mask);
endmodule

// File: rtl/tmr_evt_sync.sv
module tmr_evt_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              rise_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      rise_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], evt_i};
      rise_q <= sync_q[STAGES-2] & ~sync_q[STAGES-1];
    end
  end

  assign rise_o = rise_q;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] preload,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             flag_o,
  output logic             pfd_o,
  output logic             pfd_n_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q, pfd_q, pfd_n_q;
  logic             wrap;

  assign wrap = tick && (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      flag_q  <= 1'b0;
      pfd_q   <= 1'b0;
      pfd_n_q <= 1'b1;
    end else begin
      if (load_en)   cnt_q <= load_val;
      else if (wrap) cnt_q <= preload;
      else if (tick) cnt_q <= cnt_q + CNT_W'(1);

      if (wrap)          flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;

      if (wrap) begin
        pfd_q   <= ~pfd_q;
        pfd_n_q <= ~pfd_n_q;
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign wrap_o  = wrap;
  assign flag_o  = flag_q;
  assign pfd_o   = pfd_q;
  assign pfd_n_o = pfd_n_q;
endmodule

// File: rtl/tmr_pfd_top.sv
module tmr_pfd_top
  import tmr_pfd_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en_i,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_evt_i,
  output logic              ovf_flag_o,
  output logic              pfd_o,
  output logic              pfd_n_o
);
  reg_addr_e         addr;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  preload_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic              int_tick, ext_tick, cnt_tick, rd_block;
  logic              wr_cnt, wr_ctrl, wr_flag, run_w, wrap_w;

  assign addr     = reg_addr_e'(bus_addr);
  assign wr_cnt   = bus_wr && (addr == ADR_COUNT);
  assign wr_ctrl  = bus_wr && (addr == ADR_CTRL);
  assign wr_flag  = bus_wr && (addr == ADR_FLAG);
  assign rd_block = bus_rd && (addr == ADR_COUNT);
  assign run_w    = ctrl_q.run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      preload_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_cnt)  preload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  tmr_prescaler #(.SEL_W(PSC_SEL_W)) psc_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (!ctrl_q.run || ctrl_q.src_ext || wr_ctrl),
    .clk_en (clk_en_i),
    .sel    (ctrl_q.psc_sel),
    .tick   (int_tick)
  );

  tmr_evt_sync #(.STAGES(3)) evt_i (
    .clk    (clk),
    .rst    (rst),
    .evt_i  (ext_evt_i),
    .rise_o (ext_tick)
  );

  assign cnt_tick = ctrl_q.run && !rd_block &&
                    (ctrl_q.src_ext ? ext_tick : int_tick);

  tmr_count_core #(.CNT_W(CNT_W)) core_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (cnt_tick),
    .load_en  (wr_cnt && !ctrl_q.run),
    .load_val (bus_wdata[CNT_W-1:0]),
    .preload  (preload_q),
    .flag_clr (wr_flag),
    .cnt_o    (cnt_q),
    .wrap_o   (wrap_w),
    .flag_o   (ovf_flag_o),
    .pfd_o    (pfd_o),
    .pfd_n_o  (pfd_n_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      ADR_COUNT: rd_mux[CNT_W-1:0]  = cnt_q;
      ADR_CTRL:  rd_mux[CTRL_W-1:0] = ctrl_q;
      ADR_FLAG:  rd_mux[0]          = ovf_flag_o;
      default:   rd_mux             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/tmr_pfd_chk.sv
module tmr_pfd_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [1:0]       bus_addr,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] preload_q,
  input logic             run_w,
  input logic             wrap_w,
  input logic             ovf_flag_o,
  input logic             pfd_o,
  input logic             pfd_n_o
);
  AST_PFD_COMPLEMENT: assert property (@(posedge clk) disable iff (rst) pfd_n_o == ~pfd_o); // R4
  AST_PFD_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (rst) !$stable(pfd_o) |-> ovf_flag_o); // R4
  AST_READ_FREEZE: assert property (@(posedge clk) disable iff (rst) (bus_rd && bus_addr == 2'd0 && !bus_wr) |=> $stable(cnt_q)); // R5
  AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (rst) wrap_w |=> cnt_q == $past(preload_q)); // R3
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst) (!run_w && !(bus_wr && bus_addr == 2'd0)) |=> $stable(cnt_q)); // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst) (bus_wr && bus_addr == 2'd2 && !wrap_w) |=> !ovf_flag_o); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) (ovf_flag_o && !(bus_wr && bus_addr == 2'd2)) |=> ovf_flag_o); // R8
endmodule

bind tmr_pfd_top tmr_pfd_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .cnt_q      (cnt_q),
  .preload_q  (preload_q),
  .run_w      (run_w),
  .wrap_w     (wrap_w),
  .ovf_flag_o (ovf_flag_o),
  .pfd_o      (pfd_o),
  .pfd_n_o    (pfd_n_o)
);

// File: tb/tmr_pfd_top_tb_top.sv
module tmr_pfd_top_tb_top;
  localparam int CNT_W  = 4;
  localparam int DATA_W = 8;
  localparam int MODV   = 1 << CNT_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              clk_en_i = 1'b1;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]        bus_addr = 2'd0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              ext_evt_i = 1'b0;
  logic              ovf_flag_o, pfd_o, pfd_n_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_pfd_top #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .clk_en_i(clk_en_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_evt_i(ext_evt_i), .ovf_flag_o(ovf_flag_o), .pfd_o(pfd_o), .pfd_n_o(pfd_n_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = DATA_W'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = int'(bus_rdata);
  endtask

  task automatic wait_toggle(output int n);
    logic last;
    last = pfd_o;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (pfd_o == last && n < 5000);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v, v1, v2, n, held;
    bit steady;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(pfd_o == 1'b0, "R1 pfd", pfd_o, 0);
    check(pfd_n_o == 1'b1, "R1 pfd_n", pfd_n_o, 1);
    check(ovf_flag_o == 1'b0, "R1 flag", ovf_flag_o, 0);
    rd(2'd0, v); check(v == 0, "R1 count", v, 0);
    rd(2'd1, v); check(v == 0, "R1 ctrl", v, 0);

    // R7 / R10: stopped preload write loads counter; control readback
    wr(2'd0, 9);
    rd(2'd0, v); check(v == 9, "R7 stopped load", v, 9);
    wr(2'd1, 'h03);
    rd(2'd1, v); check(v == 'h03, "R10 ctrl readback", v, 3);
    rd(2'd3, v); check(v == 0, "R10 unused addr", v, 0);
    idle(20);
    rd(2'd0, v); check(v == 9, "R7 stopped hold", v, 9);

    // R2 single-step counting with preload 0
    wr(2'd0, 0);
    wr(2'd1, 'h10);
    rd(2'd0, v1);
    idle(5);
    rd(2'd0, v2);
    check(((v2 - v1) & (MODV - 1)) == 5, "R2 increment", (v2 - v1) & (MODV - 1), 5);

    // R5 held read freezes count and drops ticks
    bus_rd = 1'b1; bus_addr = 2'd0;
    @(negedge clk);
    held = int'(bus_rdata);
    steady = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (int'(bus_rdata) != held) steady = 0;
    end
    bus_rd = 1'b0;
    check(steady, "R5 frozen during read", int'(bus_rdata), held);
    idle(3);
    rd(2'd0, v);
    check(((v - held) & (MODV - 1)) == 3, "R5 no recovery", (v - held) & (MODV - 1), 3);

    // R2 R3 R4 exhaustive sweep of prescale stage and preload
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < MODV; p++) begin
        wr(2'd1, 0);
        wr(2'd0, p);
        wr(2'd1, 'h10 | s);
        wait_toggle(n);
        wait_toggle(n);
        check(n == ((MODV - p) << s), "R3 wrap period", n, (MODV - p) << s);
        check(pfd_n_o == ~pfd_o, "R4 complement", pfd_n_o, ~pfd_o);
      end
    end

    // R8 sticky flag and clear
    check(ovf_flag_o == 1'b1, "R8 flag set", ovf_flag_o, 1);
    wr(2'd1, 0);
    idle(5);
    rd(2'd2, v); check(v == 1, "R8 sticky", v, 1);
    wr(2'd2, 0);
    check(ovf_flag_o == 1'b0, "R8 cleared", ovf_flag_o, 0);

    // R6 external edges
    wr(2'd0, 0);
    wr(2'd1, 'h18);
    for (int k = 0; k < 7; k++) begin
      ext_evt_i = 1'b1; idle(2);
      ext_evt_i = 1'b0; idle(3);
    end
    idle(6);
    rd(2'd0, v); check(v == 7, "R6 edge count", v, 7);
    ext_evt_i = 1'b1; idle(10);
    ext_evt_i = 1'b0; idle(6);
    rd(2'd0, v); check(v == 8, "R6 held high counts once", v, 8);

    // R9 clock enable gates the internal source
    wr(2'd1, 0);
    wr(2'd0, 0);
    clk_en_i = 1'b0;
    wr(2'd1, 'h10);
    idle(10);
    rd(2'd0, v); check(v == 0, "R9 disabled", v, 0);
    clk_en_i = 1'b1;
    idle(4);
    rd(2'd0, v); check(v == 4, "R9 re-enabled", v, 4);

    // R7 running preload write leaves count alone
    wr(2'd0, 12);
    rd(2'd0, v); check(v == 5, "R7 running write", v, 5);

    finish_run();
  end
endmodule